// File: doc/BRIEF.md
# JTAG Debug Data Mailbox

This block lets an external JTAG host and an on-chip processor pass 32-bit words to each other through one shared data register. A 16-bit status word, whose bit 0 is an ownership flag, can always be scanned by the host. The same flag decides who may touch the data register and which of the two registers the data-register scan path currently reaches. A completed serial delivery raises an interrupt towards the processor.

The TAP controller and instruction decoder live elsewhere. They present one-cycle capture, shift and update strobes, a level that says the mailbox instruction is loaded, a bypass level and the TAP reset. All of these are treated as already synchronous to `clk`. The processor side is a single-cycle write port and a combinational read port with one address bit.

A typical exchange runs like this. The host polls the status word until the flag reads 1. The following scan then reaches the data register: it reads out the processor's word and loads the host's word. That update clears the flag and interrupts the processor, which consumes the word, writes a reply and then writes 1 to the flag.

Top module: `jtag_mailbox`

## Requirements
- R1: After `rst` the flag is 1, `irq` is 0, the data register holds 0 and the scan path selects the status word.
- R2: A status scan captures the 16-bit word {15 zeros, flag} and shifts it out LSB first on `tdo` (`tdi` enters bit 15). This works for either flag value, and its update never alters the data register.
- R3: An update that ends a status scan selects the data register for the next scan only if the captured flag was 1 and at least one shift has occurred. Otherwise the status word stays selected.
- R4: A data scan captures the data register and shifts 32 bits LSB first (`tdi` enters bit 31). Its update stores the shifted word, clears the flag, sets `irq` and reselects the status word.
- R5: A processor write to the data register (`cpu_addr`=1) takes effect only while the flag is 1. While the flag is 0 it is ignored.
- R6: A processor write to the status word (`cpu_addr`=0) with `cpu_wdata[0]`=1 sets the flag and clears `irq`. A write with bit 0 = 0 changes nothing.
- R7: While `trst_n` is low the flag is forced to 1, the status word is reselected and all TAP strobes are ignored.
- R8: While `bypass_sel` is high the flag is forced to 1 and all TAP strobes are ignored.
- R9: TAP strobes have no effect while `mb_sel` is low.
- R10: If a processor flag set coincides with a data-scan update, the serial word is stored, the flag ends at 1 and `irq` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trst_n | input | 1 | TAP reset, active low |
| bypass_sel | input | 1 | Bypass instruction selected |
| mb_sel | input | 1 | Mailbox data-register instruction selected |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe, one bit per pulse |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift stage) |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | 1 | 0 = status word, 1 = data register |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data for `cpu_addr` |
| irq | output | 1 | Arrival interrupt to the processor |

## Verification
The bench scans the status word twice while the flag is 0. A design that switched the multiplexer regardless of the flag would capture the data word on the second scan and overwrite it on update. The bench picks data words whose bit 0 is 0 and whose low half is non-zero, so that a scan that wrongly reached the data register (after a TAP reset, in bypass, or with the instruction deselected) shows up as a wrong status capture or a changed data word. Locked processor writes, a zero written to the flag, and a processor flag set landing in the same cycle as a serial completion are each probed. A design that lost the serial word, left the flag at 0 or dropped the interrupt in that collision would be caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    parameter int DATA_W = 32;
    parameter int STAT_W = 16;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } scan_sel_e;

    typedef struct packed {
        logic cap;
        logic shift;
        logic upd;
    } tap_strb_t;

    function automatic logic [STAT_W-1:0] status_word(input logic flag);
        logic [STAT_W-1:0] w;
        w    = '0;
        w[0] = flag;
        return w;
    endfunction

endpackage

// File: rtl/mbx_scan_stage.sv
module mbx_scan_stage
    import mbx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  tap_strb_t     strb,
    input  logic          tdi,
    input  scan_sel_e     sel,
    input  logic [SW-1:0] stat_word,
    input  logic [DW-1:0] data_word,
    output logic [DW-1:0] shreg,
    output logic          tdo
);

    logic [DW-1:0] shifted_data;
    logic [DW-1:0] shifted_stat;
    logic [DW-1:0] captured;

    always_comb begin
        shifted_data = {tdi, shreg[DW-1:1]};
        shifted_stat = '0;
        shifted_stat[SW-2:0] = shreg[SW-1:1];
        shifted_stat[SW-1]   = tdi;
        captured = (sel == SEL_DATA) ? data_word
                                     : {{(DW-SW){1'b0}}, stat_word};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (strb.cap) begin
            shreg <= captured;
        end else if (strb.shift) begin
            shreg <= (sel == SEL_DATA) ? shifted_data : shifted_stat;
        end
    end

    assign tdo = shreg[0];

    // R4: a data-chain shift puts tdi into the top bit
    p_data_shift_in_r4: assert property (@(posedge clk) disable iff (rst)
        (strb.shift && !strb.cap && sel == SEL_DATA) |=> shreg[DW-1] == $past(tdi));

    // R2: the status chain is SW bits long and tdi enters bit SW-1
    p_stat_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        (strb.shift && !strb.cap && sel == SEL_STATUS) |=>
            (shreg[SW-1] == $past(tdi)) && (shreg[DW-1:SW] == '0));

endmodule

// File: rtl/mbx_own_ctrl.sv
module mbx_own_ctrl
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trst_n,
    input  logic      bypass_sel,
    input  tap_strb_t strb,
    input  logic      cpu_flag_set,
    output logic      flag,
    output logic      irq,
    output scan_sel_e sel,
    output logic      upd_data
);

    logic seen_one;
    logic moved;
    logic force_set;

    assign force_set = !trst_n || bypass_sel || cpu_flag_set;
    assign upd_data  = strb.upd && (sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b1;
            irq      <= 1'b0;
            sel      <= SEL_STATUS;
            seen_one <= 1'b0;
            moved    <= 1'b0;
        end else begin
            if (force_set)     flag <= 1'b1;
            else if (upd_data) flag <= 1'b0;

            if (upd_data)          irq <= 1'b1;
            else if (cpu_flag_set) irq <= 1'b0;

            if (strb.cap) begin
                seen_one <= (sel == SEL_STATUS) && flag;
                moved    <= 1'b0;
            end else if (strb.shift) begin
                moved <= 1'b1;
            end

            if (!trst_n) begin
                sel <= SEL_STATUS;
            end else if (strb.upd) begin
                if (sel == SEL_DATA)
                    sel <= SEL_STATUS;
                else if (seen_one && moved)
                    sel <= SEL_DATA;
            end
        end
    end

    p_trst_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        !trst_n |=> flag && sel == SEL_STATUS);

    p_bypass_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
        bypass_sel |=> flag);

    p_commit_clears_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (strb.upd && sel == SEL_DATA && trst_n && !bypass_sel && !cpu_flag_set)
            |=> !flag && irq && sel == SEL_STATUS);

    p_cpu_set_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_flag_set && !strb.upd) |=> flag && !irq);

    p_collision_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_flag_set && strb.upd && sel == SEL_DATA) |=> flag && irq);

endmodule

// File: rtl/mbx_data_reg.sv
module mbx_data_reg
    import mbx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          flag,
    input  logic          upd_data,
    input  logic [DW-1:0] shreg,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (upd_data) begin
            data_q <= shreg;
        end else if (cpu_wr && flag) begin
            data_q <= cpu_wdata;
        end
    end

    p_locked_write_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !flag && !upd_data) |=> $stable(data_q));

    p_serial_commit_r4: assert property (@(posedge clk) disable iff (rst)
        upd_data |=> data_q == $past(shreg));

endmodule

// File: rtl/jtag_mailbox.sv
module jtag_mailbox
    import mbx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trst_n,
    input  logic          bypass_sel,
    input  logic          mb_sel,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    input  logic          cpu_we,
    input  logic          cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq
);

    localparam int PAD_W = DW - SW;

    tap_strb_t     strb;
    logic          tap_ok;
    logic          cpu_flag_set;
    logic          cpu_wr_data;
    logic          flag;
    logic          upd_data;
    scan_sel_e     sel;
    logic [DW-1:0] shreg;
    logic [DW-1:0] data_q;
    logic [SW-1:0] stat_w;

    assign tap_ok       = mb_sel && trst_n && !bypass_sel;
    assign strb.cap     = capture_dr && tap_ok;
    assign strb.shift   = shift_dr && tap_ok;
    assign strb.upd     = update_dr && tap_ok;
    assign cpu_flag_set = cpu_we && !cpu_addr && cpu_wdata[0];
    assign cpu_wr_data  = cpu_we && cpu_addr;
    assign stat_w       = status_word(flag);
    assign cpu_rdata    = cpu_addr ? data_q : {{PAD_W{1'b0}}, stat_w};

    mbx_own_ctrl u_own (
        .clk          (clk),
        .rst          (rst),
        .trst_n       (trst_n),
        .bypass_sel   (bypass_sel),
        .strb         (strb),
        .cpu_flag_set (cpu_flag_set),
        .flag         (flag),
        .irq          (irq),
        .sel          (sel),
        .upd_data     (upd_data)
    );

    mbx_scan_stage #(.DW(DW), .SW(SW)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .strb      (strb),
        .tdi       (tdi),
        .sel       (sel),
        .stat_word (stat_w),
        .data_word (data_q),
        .shreg     (shreg),
        .tdo       (tdo)
    );

    mbx_data_reg #(.DW(DW)) u_data (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr_data),
        .cpu_wdata (cpu_wdata),
        .flag      (flag),
        .upd_data  (upd_data),
        .shreg     (shreg),
        .data_q    (data_q)
    );

    // R9: strobes with the instruction deselected leave the scan state alone
    p_deselect_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!mb_sel && trst_n) |=> $stable(shreg) && $stable(sel));

endmodule

// File: tb/tb_jtag_mailbox.sv
module tb_jtag_mailbox;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trst_n = 1'b1;
    logic        bypass_sel = 1'b0;
    logic        mb_sel = 1'b1;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        cpu_we = 1'b0;
    logic        cpu_addr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    jtag_mailbox dut (
        .clk(clk), .rst(rst), .trst_n(trst_n), .bypass_sel(bypass_sel),
        .mb_sel(mb_sel), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        cpu_addr = a;
        #0.5;
        v = cpu_rdata;
    endtask

    task automatic cpu_wr(input logic a, input logic [31:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_we = 1'b0;
    endtask

    task automatic scan(input int len, input logic [31:0] din,
                        input logic coll, output logic [31:0] dout);
        dout = '0;
        capture_dr = 1'b1; tick(); capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            shift_dr = 1'b1; tick(); shift_dr = 1'b0;
        end
        update_dr = 1'b1;
        if (coll) begin cpu_we = 1'b1; cpu_addr = 1'b0; cpu_wdata = 32'h1; end
        tick();
        update_dr = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 flag", v, 32'h1);
        rd(1'b1, v); chk("R1 data", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_first_round();
        logic [31:0] v;
        scan(16, 32'h0, 1'b0, v);
        chk("R2 status capture", v, 32'h1);
        scan(32, 32'hC3A5_5A3C, 1'b0, v);
        chk("R4 old data out", v, 32'h0);
        rd(1'b1, v); chk("R4 data stored", v, 32'hC3A5_5A3C);
        rd(1'b0, v); chk("R4 flag cleared", v, 32'h0);
        chk("R4 irq", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_poll_flag_zero();
        logic [31:0] v;
        scan(16, 32'h0, 1'b0, v);
        chk("R2 monitor flag0", v, 32'h0);
        scan(16, 32'hFFFF, 1'b0, v);
        chk("R3 stays on status", v, 32'h0);
        rd(1'b1, v); chk("R3 data untouched", v, 32'hC3A5_5A3C);
    endtask

    task automatic t_cpu_side();
        logic [31:0] v;
        cpu_wr(1'b1, 32'h1111_2222);
        rd(1'b1, v); chk("R5 locked write", v, 32'hC3A5_5A3C);
        cpu_wr(1'b0, 32'h0);
        rd(1'b0, v); chk("R6 zero write", v, 32'h0);
        cpu_wr(1'b0, 32'h1);
        rd(1'b0, v); chk("R6 flag set", v, 32'h1);
        chk("R6 irq clear", {31'b0, irq}, 32'h0);
        cpu_wr(1'b1, 32'h8765_4320);
        rd(1'b1, v); chk("R5 open write", v, 32'h8765_4320);
    endtask

    task automatic t_second_round();
        logic [31:0] v;
        scan(16, 32'h0, 1'b0, v);
        scan(32, 32'h0F0F_A5A4, 1'b0, v);
        chk("R4 reply out", v, 32'h8765_4320);
        rd(1'b1, v); chk("R4 second store", v, 32'h0F0F_A5A4);
    endtask

    task automatic t_deselect();
        logic [31:0] v;
        cpu_wr(1'b0, 32'h1);
        mb_sel = 1'b0;
        scan(16, 32'h0, 1'b0, v);
        mb_sel = 1'b1;
        scan(16, 32'h0, 1'b0, v);
        chk("R9 status still selected", v, 32'h1);
        mb_sel = 1'b0;
        scan(32, 32'hDEAD_BEE0, 1'b0, v);
        mb_sel = 1'b1;
        rd(1'b1, v); chk("R9 data untouched", v, 32'h0F0F_A5A4);
        rd(1'b0, v); chk("R9 flag untouched", v, 32'h1);
    endtask

    task automatic t_tap_reset();
        logic [31:0] v;
        scan(32, 32'h1234_5670, 1'b0, v);
        rd(1'b0, v); chk("R4 flag cleared again", v, 32'h0);
        trst_n = 1'b0; tick();
        rd(1'b0, v); chk("R7 flag forced", v, 32'h1);
        trst_n = 1'b1;
        scan(16, 32'h0, 1'b0, v);
        trst_n = 1'b0; tick(); trst_n = 1'b1;
        scan(16, 32'h0, 1'b0, v);
        chk("R7 status reselected", v, 32'h1);
        rd(1'b1, v); chk("R7 data kept", v, 32'h1234_5670);
    endtask

    task automatic t_bypass();
        logic [31:0] v;
        scan(32, 32'h2468_ACE0, 1'b0, v);
        bypass_sel = 1'b1; tick();
        rd(1'b0, v); chk("R8 flag forced", v, 32'h1);
        bypass_sel = 1'b0;
        cpu_wr(1'b0, 32'h1);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
        scan(16, 32'h0, 1'b0, v);
        bypass_sel = 1'b1;
        scan(32, 32'hFFFF_0000, 1'b0, v);
        bypass_sel = 1'b0;
        rd(1'b1, v); chk("R8 data untouched", v, 32'h2468_ACE0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        scan(32, 32'h5555_AAAA, 1'b1, v);
        chk("R8 scan still on data", v, 32'h2468_ACE0);
        rd(1'b1, v); chk("R10 serial word kept", v, 32'h5555_AAAA);
        rd(1'b0, v); chk("R10 flag set wins", v, 32'h1);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        t_reset();
        t_first_round();
        t_poll_flag_zero();
        t_cpu_side();
        t_second_round();
        t_deselect();
        t_tap_reset();
        t_bypass();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule